// File: doc/BRIEF.md
# Two-Buffer Receive Frame Steering Controller

This block sits behind an Ethernet receive frame validator and decides where each incoming frame goes. Two receive buffers, numbered 0 and 1, are filled in turn. The block turns the byte stream into write strobes and byte offsets for the chosen buffer. When the validator reports the end of the frame, the block settles the frame's outcome. The frame is either completed into its buffer, rejected as an overrun, reported as an error, taken as a flow-control pause frame, or dropped because no buffer is free.

The host reads a completed buffer using the end-of-frame pointer that goes with it. It then hands the buffer back with a one-cycle clear pulse. Each buffer raises an interrupt request while its complete flag is set and its enable is high. Error, pause and babble outcomes appear as one-cycle event strobes. Overruns leave a sticky flag on the buffer concerned.

Top module: `rx_pingpong_ctrl`

## Requirements
- R1: After reset the target pointer names buffer 0. A frame goes to the target buffer when that buffer's complete flag is clear, otherwise to the other buffer. After a completed frame the target becomes the buffer not just filled, so good frames alternate 0, 1, 0, ...
- R2: Each byte of a stored frame raises `wrEn` in the cycle it is presented. `wrAddr` equals the byte's offset from 0 and `wrBuf` names the chosen buffer. Only the first DEPTH bytes are written.
- R3: One cycle after the end-of-frame cycle, a frame that was stored, did not overrun, and carries neither the error nor the pause mark sets its buffer's complete flag. In the same cycle that buffer's pointer takes the byte count minus one.
- R4: A frame that begins while both complete flags are set is dropped. It produces no write, no flag change and no event, except as allowed by R5.
- R5: A frame marked pause and not marked error pulses `pauseEvt` one cycle after its end. This happens even when the frame was dropped under R4. Such a frame never sets a complete flag. An overrun frame gives no pause event.
- R6: A stored frame marked error that did not overrun pulses `errEvt` one cycle after its end, and sets no complete flag.
- R7: A stored frame longer than DEPTH bytes sets that buffer's overrun flag one cycle after its end. It gives no complete flag, no `errEvt` and no `pauseEvt`.
- R8: `babbleIn` seen during a stored frame, before the byte that overruns the buffer, pulses `babEvt` one cycle after the frame end. A babble seen in or after the overrunning byte is ignored, as is any babble during a dropped frame.
- R9: A `clrDone` bit clears that buffer's complete and overrun flags in the next cycle. It wins over a set in the same cycle.
- R10: `irq[i]` is high exactly when `done[i]` and `irqEn[i]` are both high.
- R11: A frame whose first byte arrives in the cycle right after the previous end-of-frame cycle is handled fully. It sees the flags that frame left behind.
- R12: During and right after reset, all flags, events, pointers and `wrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A frame byte is present this cycle |
| byteData | input | 8 | Frame byte |
| babbleIn | input | 1 | Validator flags the frame as too long |
| eofValid | input | 1 | End of frame, one cycle with no byte |
| eofErr | input | 1 | Frame carried a receive error (valid with eofValid) |
| eofPause | input | 1 | Frame is a flow-control pause frame (valid with eofValid) |
| clrDone | input | 2 | Host clear pulse per buffer |
| irqEn | input | 2 | Completion interrupt enable per buffer |
| wrEn | output | 1 | Buffer write strobe |
| wrBuf | output | 1 | Buffer being written |
| wrAddr | output | log2(DEPTH) | Byte offset inside the buffer |
| wrData | output | 8 | Byte to write |
| done | output | 2 | Complete flag per buffer |
| ovr | output | 2 | Sticky overrun flag per buffer |
| eofPtrA | output | log2(DEPTH) | Offset of last byte in buffer 0 |
| eofPtrB | output | log2(DEPTH) | Offset of last byte in buffer 1 |
| irq | output | 2 | Completion interrupt request per buffer |
| errEvt | output | 1 | One-cycle receive error event |
| pauseEvt | output | 1 | One-cycle pause frame accepted event |
| babEvt | output | 1 | One-cycle babble event |

## Verification
The write strobe, address and buffer select are combinational, so the bench checks them in the same cycle that it presents each byte. It drives on the falling edge and samples a nanosecond later. Frame outcomes (flags, pointer, events) are registered once, so they are checked at the falling edge after the end-of-frame cycle, while the event strobes are still high. Clear pulses are checked one cycle after the pulse. The interrupt lines are compared with the modelled flags at each of those points. Back-to-back frames put their first byte on that same sampling edge, which tests the zero-idle restart.

// File: rtl/rx_pingpong_pkg.sv
package rx_pingpong_pkg;
  typedef struct packed {
    logic start;    // first byte of a frame
    logic step;     // further byte inside a frame
    logic latchPtr; // capture end pointer
    logic ptrSel;   // which pointer to capture
  } dpCtl_t;
endpackage

// File: rtl/rx_pingpong_dp.sv
module rx_pingpong_dp
  import rx_pingpong_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [7:0]    byteData,
  output logic          atLimit,
  output logic [AW-1:0] wrAddr,
  output logic [7:0]    wrData,
  output logic [AW-1:0] eofPtr [2]
);
  logic [CW-1:0] byteCnt;

  always_ff @(posedge clk) begin
    if (!rstN) byteCnt <= '0;
    else if (ctl.start) byteCnt <= CW'(1);
    else if (ctl.step && !atLimit) byteCnt <= byteCnt + CW'(1);
  end

  assign atLimit = (byteCnt == CW'(DEPTH));
  assign wrAddr  = ctl.start ? '0 : byteCnt[AW-1:0];
  assign wrData  = byteData;

  for (genvar b = 0; b < 2; b++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN) eofPtr[b] <= '0;
      else if (ctl.latchPtr && ctl.ptrSel == 1'(b))
        eofPtr[b] <= AW'(byteCnt - CW'(1));
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CW'(DEPTH));
endmodule

// File: rtl/rx_pingpong_ctl.sv
module rx_pingpong_ctl
  import rx_pingpong_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       babbleIn,
  input  logic       eofValid,
  input  logic       eofErr,
  input  logic       eofPause,
  input  logic [1:0] clrDone,
  input  logic       atLimit,
  output dpCtl_t     ctl,
  output logic       wrEn,
  output logic       wrBuf,
  output logic [1:0] done,
  output logic [1:0] ovr,
  output logic       errEvt,
  output logic       pauseEvt,
  output logic       babEvt
);
  logic active, dropping, tgt, nextBuf, ovrSeen, babSeen;
  logic startNow, pickBuf, curBuf, curDrop, ovfNow, endNow, setDone, setOvr;

  assign startNow = byteValid && !active;
  assign pickBuf  = done[nextBuf] ? ~nextBuf : nextBuf;
  assign curBuf   = startNow ? pickBuf : tgt;
  assign curDrop  = startNow ? &done : dropping;
  assign ovfNow   = byteValid && active && !dropping && atLimit;
  assign endNow   = eofValid && active;
  assign setOvr   = endNow && !dropping && ovrSeen;
  assign setDone  = endNow && !dropping && !ovrSeen && !eofErr && !eofPause;

  assign wrEn  = byteValid && !curDrop && (startNow || !atLimit);
  assign wrBuf = curBuf;

  assign ctl.start    = startNow;
  assign ctl.step     = byteValid && active;
  assign ctl.latchPtr = setDone;
  assign ctl.ptrSel   = tgt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0; dropping <= 1'b0; tgt <= 1'b0; nextBuf <= 1'b0;
      ovrSeen <= 1'b0; babSeen <= 1'b0;
      errEvt <= 1'b0; pauseEvt <= 1'b0; babEvt <= 1'b0;
    end else begin
      errEvt   <= endNow && !dropping && !ovrSeen && eofErr;
      pauseEvt <= endNow && !(!dropping && ovrSeen) && !eofErr && eofPause;
      babEvt   <= endNow && !dropping && babSeen;
      if (startNow) begin
        active   <= 1'b1;
        dropping <= &done;
        tgt      <= pickBuf;
        ovrSeen  <= 1'b0;
        babSeen  <= babbleIn;
      end else if (active) begin
        if (ovfNow) ovrSeen <= 1'b1;
        if (babbleIn && !ovrSeen && !ovfNow) babSeen <= 1'b1;
        if (endNow) active <= 1'b0;
      end
      if (setDone) nextBuf <= ~tgt;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        done[b] <= 1'b0;
        ovr[b]  <= 1'b0;
      end else if (clrDone[b]) begin
        done[b] <= 1'b0;
        ovr[b]  <= 1'b0;
      end else begin
        if (setDone && tgt == 1'(b)) done[b] <= 1'b1;
        if (setOvr && tgt == 1'(b))  ovr[b]  <= 1'b1;
      end
    end

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      clrDone[b] |=> !done[b] && !ovr[b]);
    // R7
    ovr_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovr[b]) |-> !$rose(done[b]));
  end

  // R6
  err_pause_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(errEvt && pauseEvt));
  // R4
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !active && done == 2'b11) |-> !wrEn);
  // R3
  done_needs_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!endNow && !clrDone[0]) |=> !$rose(done[0]));
endmodule

// File: rtl/rx_pingpong_ctrl.sv
module rx_pingpong_ctrl
  import rx_pingpong_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          byteValid,
  input  logic [7:0]    byteData,
  input  logic          babbleIn,
  input  logic          eofValid,
  input  logic          eofErr,
  input  logic          eofPause,
  input  logic [1:0]    clrDone,
  input  logic [1:0]    irqEn,
  output logic          wrEn,
  output logic          wrBuf,
  output logic [AW-1:0] wrAddr,
  output logic [7:0]    wrData,
  output logic [1:0]    done,
  output logic [1:0]    ovr,
  output logic [AW-1:0] eofPtrA,
  output logic [AW-1:0] eofPtrB,
  output logic [1:0]    irq,
  output logic          errEvt,
  output logic          pauseEvt,
  output logic          babEvt
);
  dpCtl_t        ctl;
  logic          atLimit;
  logic [AW-1:0] eofPtr [2];

  rx_pingpong_ctl u_ctl (
    .clk, .rstN, .byteValid, .babbleIn, .eofValid, .eofErr, .eofPause,
    .clrDone, .atLimit, .ctl, .wrEn, .wrBuf, .done, .ovr,
    .errEvt, .pauseEvt, .babEvt
  );

  rx_pingpong_dp #(.DEPTH(DEPTH)) u_dp (
    .clk, .rstN, .ctl, .byteData, .atLimit, .wrAddr, .wrData, .eofPtr
  );

  assign eofPtrA = eofPtr[0];
  assign eofPtrB = eofPtr[1];
  assign irq     = done & irqEn;

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq[1] |-> done[1] && irqEn[1]);
endmodule

// File: tb/rx_pingpong_ctrl_test.sv
module rx_pingpong_ctrl_test;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 0, babbleIn = 0, eofValid = 0, eofErr = 0, eofPause = 0;
  logic [7:0] byteData = '0;
  logic [1:0] clrDone = '0, irqEn = '0;
  logic wrEn, wrBuf, errEvt, pauseEvt, babEvt;
  logic [AW-1:0] wrAddr, eofPtrA, eofPtrB;
  logic [7:0] wrData;
  logic [1:0] done, ovr, irq;

  rx_pingpong_ctrl #(.DEPTH(DEPTH)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [1:0] mDone = '0, mOvr = '0;
  int mPtr [2] = '{0, 0};
  logic mNext = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pickTarget(logic [1:0] d, logic nb);
    return d[nb] ? ~nb : nb;
  endfunction

  task automatic checkFlags(string tag);
    chk({tag, " R3 done"}, int'(done), int'(mDone));
    chk({tag, " R7 ovr"}, int'(ovr), int'(mOvr));
    chk({tag, " R3 ptrA"}, int'(eofPtrA), mPtr[0]);
    chk({tag, " R3 ptrB"}, int'(eofPtrB), mPtr[1]);
    chk({tag, " R10 irq"}, int'(irq), int'(mDone & irqEn));
  endtask

  task automatic sendFrame(int len, bit err, bit pause, int babAt,
                           logic [1:0] clrAtEof, bit tight);
    bit drop, ovf, expErr, expPause, expBab, expDone;
    logic tgt;
    drop = &mDone;
    tgt = pickTarget(mDone, mNext);
    ovf = !drop && len > DEPTH;
    for (int k = 0; k < len; k++) begin
      if (!(tight && k == 0)) @(negedge clk);
      byteValid = 1'b1;
      byteData = 8'($urandom);
      babbleIn = (k == babAt);
      #1;
      chk("R2/R4 wrEn", int'(wrEn), int'(!drop && k < DEPTH));
      if (!drop && k < DEPTH) begin
        chk("R2 wrAddr", int'(wrAddr), k);
        chk("R1 wrBuf", int'(wrBuf), int'(tgt));
        chk("R2 wrData", int'(wrData), int'(byteData));
      end
    end
    @(negedge clk);
    byteValid = 1'b0; babbleIn = 1'b0;
    eofValid = 1'b1; eofErr = err; eofPause = pause; clrDone = clrAtEof;
    expErr   = !drop && !ovf && err;
    expPause = !ovf && !err && pause;
    expBab   = !drop && babAt >= 0 && babAt < len && babAt < DEPTH;
    expDone  = !drop && !ovf && !err && !pause;
    if (expDone) begin
      mDone[tgt] = 1'b1;
      mPtr[tgt] = (len - 1) % DEPTH;
      mNext = ~tgt;
    end
    if (ovf) mOvr[tgt] = 1'b1;
    mDone &= ~clrAtEof;
    mOvr &= ~clrAtEof;
    @(negedge clk);
    eofValid = 1'b0; eofErr = 1'b0; eofPause = 1'b0; clrDone = '0;
    #1;
    chk("R6 errEvt", int'(errEvt), int'(expErr));
    chk("R5 pauseEvt", int'(pauseEvt), int'(expPause));
    chk("R8 babEvt", int'(babEvt), int'(expBab));
    checkFlags("R9/R11 end");
  endtask

  task automatic clearBufs(logic [1:0] m);
    @(negedge clk);
    clrDone = m;
    @(negedge clk);
    clrDone = '0;
    mDone &= ~m;
    mOvr &= ~m;
    #1;
    checkFlags("R9 clear");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R12 wrEn", int'(wrEn), 0);
    chk("R12 events", int'({errEvt, pauseEvt, babEvt}), 0);
    checkFlags("R12 in reset");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkFlags("R12 after reset");
    irqEn = 2'b11;

    sendFrame(5, 0, 0, -1, 2'b00, 0);        // R1 buffer 0
    sendFrame(DEPTH, 0, 0, -1, 2'b00, 1);    // R1 buffer 1, R11 tight, exact fill
    sendFrame(4, 0, 0, 2, 2'b00, 0);         // R4 dropped, babble ignored
    sendFrame(3, 0, 1, -1, 2'b00, 1);        // R5 pause while full
    sendFrame(3, 1, 1, -1, 2'b00, 0);        // R5 pause with error while full
    irqEn = 2'b01;
    clearBufs(2'b01);                        // R9, R10
    sendFrame(6, 0, 0, -1, 2'b00, 0);        // R1 goes to free buffer 0
    clearBufs(2'b11);
    sendFrame(DEPTH + 3, 0, 0, DEPTH, 2'b00, 0); // R7 overrun, R8 late babble
    sendFrame(DEPTH + 2, 0, 1, 2, 2'b00, 0);     // R7/R8 early babble, no pause
    sendFrame(7, 1, 0, -1, 2'b00, 0);        // R6 error
    sendFrame(4, 0, 1, 1, 2'b00, 0);         // R5 pause stored, R8 babble
    sendFrame(2, 0, 0, -1, 2'b11, 1);        // R9 clear wins over set
    clearBufs(2'b11);

    for (int n = 0; n < 80; n++) begin
      int len, babAt;
      len = 1 + int'($urandom % (DEPTH + 6));
      babAt = ($urandom % 4 == 0) ? int'($urandom % (len + 2)) : -1;
      sendFrame(len, ($urandom % 6) == 0, ($urandom % 6) == 0, babAt,
                ($urandom % 4 == 0) ? 2'($urandom) : 2'b00,
                ($urandom % 3) == 0);
      if ($urandom % 3 == 0) begin
        irqEn = 2'($urandom);
        clearBufs(2'($urandom));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule